// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 four-bit words. The host side has a valid/ready request port: a request carries a direction bit, an 18-bit word address and a 4-bit write value. A read returns its data with a single-cycle valid pulse. The memory side drives active-low chip-select, output-enable and write-strobe pins, the address lines, and a 4-bit data bus that is split into an output value, a drive enable and an input value, so a pad ring can build the tristate.

All analogue timing is given in picoseconds, together with the clock period. At elaboration each figure is rounded up to whole clock cycles, with a floor of one cycle. A single down-counter times every phase of the access. Chip-select is dropped whenever no access is in flight, which leaves the memory in its low-power standby state between requests. After every read the bus is left quiet long enough for the memory's output drivers to float before the controller can drive it again.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst` is high, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: Whenever `req_ready` is 1 (no access in flight), `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_dq_oe` is 0.
- R3: A read (`req_write`=0) selects the chip and holds the address for ASU cycles with `mem_oe_n` high, then holds `mem_oe_n` low for ACC = ceil(ACC_PS/CLK_PS) cycles. The value on `mem_dq_i` at the last of those cycles is returned on `rsp_rdata` with `rsp_valid`=1 in the ASU+ACC-th cycle, counting the cycle after the accepting edge as cycle 0.
- R4: A write (`req_write`=1) holds the chip selected and the address stable for ASU cycles before `mem_we_n` falls. It keeps `mem_we_n` low for PULSE = max(ceil(WE_PULSE_PS/CLK_PS), ceil(DATA_SETUP_PS/CLK_PS)) cycles and drives the request data for the whole pulse. `mem_we_n` rises while chip-select is still low and the address is unchanged.
- R5: `mem_dq_oe` is asserted only after `mem_oe_n` has been high for at least HIZ = ceil(OE_HIZ_PS/CLK_PS) cycles, so the bus is never driven from both sides.
- R6: `mem_dq_oe` is 1 only while `mem_ce_n` is 0.
- R7: After the read data is captured, `mem_ce_n` and `mem_oe_n` stay high for HIZ cycles before `req_ready` returns.
- R8: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 on the next cycle. Address, data and direction are latched at that edge, and later changes to them have no effect on the access.
- R9: Each read produces exactly one single-cycle `rsp_valid` pulse, and a write produces none.
- R10: A write keeps `req_ready` low for ASU+PULSE+REC cycles, where REC = max(1, ceil(WR_CYCLE_PS/CLK_PS)-ASU-PULSE). A read keeps it low for ASU+ACC+HIZ cycles.
- R11: `mem_oe_n` and `mem_we_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write value |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read value |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dq_o | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | DATA_W | Value sampled from the data bus |

## Verification
On every cycle the in-RTL assertions check the following: the pin quiet state while idle, the exclusion of output-enable and write strobe, drive enable only under chip-select and only after the output-enable high count, the ordering of chip-select, address and write-strobe edges, and the single-cycle response strobe. The exact phase lengths, the refusal of new requests during an access and the correctness of the returned data can only be shown by the bench. Its cycle-level memory model returns corrupt data before the access count elapses, drives the bus through the float delay, and checks the pulse width, data setup and contention. The bench sweeps every address of a small configuration with two arithmetic patterns, including write-then-read back to back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_SETUP = 3'd1,
    ST_RD_WAIT  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_RECOV = 3'd5,
    ST_TURN     = 3'd6
  } sram_st_e;

  // round a picosecond figure up to whole clock cycles
  function automatic int cyc_ceil(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int floor1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  // a phase of N cycles loads N-1 and ends in the cycle the count reads zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int ASU_CYC   = 1,
  parameter int ACC_CYC   = 3,
  parameter int HIZ_CYC   = 2,
  parameter int PULSE_CYC = 3,
  parameter int REC_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output sram_st_e         st_q,
  output sram_st_e         st_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             capture
);

  localparam logic [CNT_W-1:0] LD_ASU   = CNT_W'(ASU_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HIZ   = CNT_W'(HIZ_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(REC_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign req_ready = (st_q == ST_IDLE);

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d     = req_write ? ST_WR_SETUP : ST_RD_SETUP;
          tmr_load = 1'b1;
          tmr_val  = LD_ASU;
        end
      end
      ST_RD_SETUP: begin
        if (tmr_done) begin
          st_d     = ST_RD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = LD_ACC;
        end
      end
      ST_RD_WAIT: begin
        if (tmr_done) begin
          st_d     = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = LD_HIZ;
          capture  = 1'b1;
        end
      end
      ST_TURN: begin
        if (tmr_done) st_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        if (tmr_done) begin
          st_d     = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          st_d     = ST_WR_RECOV;
          tmr_load = 1'b1;
          tmr_val  = LD_REC;
        end
      end
      ST_WR_RECOV: begin
        if (tmr_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // R8: a taken request closes the port for at least the following cycle
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R3: capture only ever ends the access wait of a read
  assert_capture_in_read_R3: assert property (@(posedge clk) disable iff (rst)
    capture |-> (st_q == ST_RD_WAIT) && tmr_done);

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  sram_st_e          st_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  // every pin is a flop fed from the next-state decode, so it lines up with the state register
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      mem_ce_n  <= (st_d == ST_IDLE) || (st_d == ST_TURN);
      mem_oe_n  <= (st_d != ST_RD_WAIT);
      mem_we_n  <= (st_d != ST_WR_PULSE);
      mem_dq_oe <= (st_d == ST_WR_PULSE) || (st_d == ST_WR_RECOV);
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_i;
    end
  end

  // R9: the response strobe never lasts two cycles
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 4,
  parameter int CLK_PS         = 4000,
  parameter int ACC_PS         = 12000,
  parameter int OE_HIZ_PS      = 6000,
  parameter int WE_PULSE_PS    = 10000,
  parameter int DATA_SETUP_PS  = 7000,
  parameter int WR_CYCLE_PS    = 12000,
  parameter int ADDR_SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int ASU_CYC   = floor1(ADDR_SETUP_CYC);
  localparam int ACC_CYC   = floor1(cyc_ceil(ACC_PS, CLK_PS));
  localparam int HIZ_CYC   = floor1(cyc_ceil(OE_HIZ_PS, CLK_PS));
  localparam int PULSE_CYC = floor1(imax(cyc_ceil(WE_PULSE_PS, CLK_PS),
                                         cyc_ceil(DATA_SETUP_PS, CLK_PS)));
  localparam int REC_CYC   = floor1(cyc_ceil(WR_CYCLE_PS, CLK_PS) - ASU_CYC - PULSE_CYC);
  localparam int MAX_CYC   = imax(imax(ASU_CYC, ACC_CYC),
                                  imax(imax(HIZ_CYC, PULSE_CYC), REC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  sram_st_e         st_q, st_d;
  logic             tmr_load, tmr_done, capture, accept;
  logic [CNT_W-1:0] tmr_val;

  assign accept = req_valid && req_ready;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .ASU_CYC   (ASU_CYC),
    .ACC_CYC   (ACC_CYC),
    .HIZ_CYC   (HIZ_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .st_q      (st_q),
    .st_d      (st_d),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_ready (req_ready),
    .capture   (capture)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_d      (st_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .mem_dq_i  (mem_dq_i),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // run length of output-enable high, saturating at the float count; checker state only
  logic [CNT_W-1:0] oe_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)                           oe_hi_cnt <= CNT_W'(HIZ_CYC);
    else if (!mem_oe_n)                oe_hi_cnt <= '0;
    else if (oe_hi_cnt < CNT_W'(HIZ_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_drive_after_float_R5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (oe_hi_cnt >= CNT_W'(HIZ_CYC)));

  assert_drive_selected_R6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_ce_n);

  assert_oe_we_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  assert_we_fall_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr)));

  assert_we_rise_selected_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_addr)));

  assert_rsp_after_oe_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!mem_oe_n));

  assert_oe_rise_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> mem_ce_n);

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

  localparam int AW       = 6;
  localparam int DW       = 4;
  localparam int DEPTH    = 1 << AW;
  localparam int CLK_PS   = 4000;
  localparam int E_ASU    = 1;
  localparam int E_ACC    = (12000 + CLK_PS - 1) / CLK_PS;
  localparam int E_HIZ    = (6000 + CLK_PS - 1) / CLK_PS;
  localparam int P_WE     = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int P_DS     = (7000 + CLK_PS - 1) / CLK_PS;
  localparam int E_PULSE  = (P_WE > P_DS) ? P_WE : P_DS;
  localparam int WC_CYC   = (24000 + CLK_PS - 1) / CLK_PS;
  localparam int E_REC    = (WC_CYC - E_ASU - E_PULSE < 1) ? 1 : WC_CYC - E_ASU - E_PULSE;
  localparam int WR_LEN   = E_ASU + E_PULSE + E_REC;
  localparam int RD_RSP   = E_ASU + E_ACC;
  localparam int RD_LEN   = E_ASU + E_ACC + E_HIZ;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i;

  int checks = 0;
  int failures = 0;
  int viol4 = 0;
  int viol5 = 0;
  int bad6 = 0;
  int bad11 = 0;

  always #2 clk = ~clk;

  sram_ctrl #(
    .ADDR_W      (AW),
    .DATA_W      (DW),
    .CLK_PS      (CLK_PS),
    .WR_CYCLE_PS (24000)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_i  (mem_dq_i)
  );

  // cycle-level memory model, evaluated at the falling edge
  logic [DW-1:0] marr [DEPTH];
  int            rd_cnt, hiz_left, we_cnt, d_stab;
  bit            wr_act, prev_ce_low, reading, writing;
  logic [AW-1:0] w_addr, prev_addr;
  logic [DW-1:0] w_data;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) marr[i] = '0;
      rd_cnt = 0; hiz_left = 0; we_cnt = 0; d_stab = 0;
      wr_act = 0; prev_ce_low = 0; prev_addr = '0; w_addr = '0; w_data = '0;
      mem_dq_i <= '0;
    end else begin
      reading = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (reading) rd_cnt = (rd_cnt > 0 && mem_addr == prev_addr) ? rd_cnt + 1 : 1;
      else         rd_cnt = 0;
      if (mem_dq_oe && (reading || hiz_left > 0)) begin
        viol5++;
        $display("model: bus driven from both sides at %0t", $time);
      end
      hiz_left = reading ? E_HIZ : ((hiz_left > 0) ? hiz_left - 1 : 0);
      if (reading) mem_dq_i <= (rd_cnt >= E_ACC) ? marr[mem_addr] : ~marr[mem_addr];
      else         mem_dq_i <= '0;
      if (mem_dq_oe && mem_ce_n) bad6++;
      if (!mem_oe_n && !mem_we_n) bad11++;
      writing = !mem_ce_n && !mem_we_n;
      if (writing) begin
        if (!wr_act) begin
          if (!(prev_ce_low && prev_addr == mem_addr)) viol4++;
          we_cnt = 1; w_addr = mem_addr; w_data = mem_dq_o;
          d_stab = mem_dq_oe ? 1 : 0; wr_act = 1;
        end else begin
          we_cnt++;
          if (mem_addr != w_addr) viol4++;
          if (mem_dq_oe && mem_dq_o == w_data) d_stab++;
          else begin w_data = mem_dq_o; d_stab = mem_dq_oe ? 1 : 0; end
        end
      end else if (wr_act) begin
        if (we_cnt < E_PULSE || d_stab < P_DS) begin
          viol4++;
          $display("model: write strobe %0d cycles, data setup %0d cycles", we_cnt, d_stab);
        end
        marr[w_addr] = w_data;
        wr_act = 0;
      end
      prev_ce_low = !mem_ce_n;
      prev_addr   = mem_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat1(input int a);
    return DW'(a * 5 + 9);
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int  j = 0;
    bit  seen = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    // R8: fields scrambled right after acceptance must not reach the memory
    req_valid = 0; req_write = 0; req_addr = ~a; req_wdata = ~d;
    @(negedge clk);
    while (!req_ready && j < 100) begin
      if (rsp_valid) seen = 1;
      j++;
      @(negedge clk);
    end
    check(j == WR_LEN, "R10 write occupancy", j, WR_LEN);
    check(!seen, "R9 no response for write", seen, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int            j = 0;
    int            j_rsp = -1;
    int            pulses = 0;
    bit            turn_bad = 0;
    logic [DW-1:0] got = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = '0;
    @(posedge clk); #1;
    req_valid = 0; req_write = 1; req_addr = ~a;
    @(negedge clk);
    while (!req_ready && j < 100) begin
      if (rsp_valid) begin pulses++; j_rsp = j; got = rsp_rdata; end
      if (j > RD_RSP - 1 && (!mem_ce_n || !mem_oe_n)) turn_bad = 1;
      j++;
      @(negedge clk);
    end
    if (rsp_valid) pulses++;
    check(got == exp, "R3 read data", got, exp);
    check(j_rsp == RD_RSP, "R3 response cycle", j_rsp, RD_RSP);
    check(pulses == 1, "R9 single response", pulses, 1);
    check(j == RD_LEN, "R10 read occupancy", j, RD_LEN);
    check(!turn_bad, "R7 deselected during turnaround", turn_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
          {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_oe && !rsp_valid, "R1 bus and response idle in reset",
          {mem_dq_oe, rsp_valid}, 0);
    check(req_ready, "R1 ready in reset", req_ready, 1);
    rst = 0;
    repeat (3) @(negedge clk);
    // R2: idle with no request pending
    check(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R2 idle pins", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 30);

    // R4: fill every address with the first pattern
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pat1(a));
    // R3: read every address back in ascending order
    for (int a = 0; a < DEPTH; a++) do_read(AW'(a), pat1(a));
    // R5: write then read back to back with the inverted pattern
    for (int a = 0; a < DEPTH; a++) begin
      do_write(AW'(a), ~pat1(a));
      do_read(AW'(a), ~pat1(a));
    end
    // R8: descending sweep shows no write landed on a scrambled address
    for (int a = DEPTH - 1; a >= 0; a--) do_read(AW'(a), ~pat1(a));
    // R8: a new request during an idle gap after two reads in a row
    do_read(AW'(5), ~pat1(5));
    do_read(AW'(6), ~pat1(6));
    repeat (2) @(negedge clk);
    check(mem_ce_n && req_ready, "R2 deselected between accesses", {mem_ce_n, req_ready}, 3);

    check(viol4 == 0, "R4 write timing in memory model", viol4, 0);
    check(viol5 == 0, "R5 bus contention in memory model", viol5, 0);
    check(bad6 == 0, "R6 drive only while selected", bad6, 0);
    check(bad11 == 0, "R11 output enable and write strobe overlap", bad11, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule